// File: doc/BRIEF.md
# Tiny Four-Bit Single-Cycle Processor

This block is a very small processor with a 4-bit datapath. It runs one instruction on each clock edge at which an outside clock-enable pulse (`tick`) is high. The program is a fixed image of eight 12-bit words, given as a parameter. A 3-bit program counter steps through the image and wraps from the last word back to the first. Data lives in eight 4-bit registers. Index 0 of the register bank is not storage: it always reads as zero. Because of this, one adder/subtractor also serves for negation, and a conditional jump on index 0 acts as an unconditional jump.

Register 7 drives the display output. To show a value, the program adds it into register 7. To blank the display, it moves zero into register 7. Two flag outputs report on the most recent add or subtract: one says the result was zero, the other says the signed result overflowed. A jump on register 0 whose target is its own address parks the processor in place, and the program ends there.

Top module: `nano4_core`

## Requirements
- R1: While `rst_n` is low and after it is released, `disp_o`, `zero_o` and `ovf_o` are 0, every register reads 0, and the first instruction executed is the word at address 0.
- R2: Opcode bits [11:10] = 00 (add): the register named by bits [9:7] is loaded with itself plus the register named by bits [6:4], modulo 16.
- R3: Opcode 01 (subtract): the register named by [9:7] (Ra) is loaded with Rb − Ra modulo 16, where Rb is named by [6:4]. With [6:4] = 0 this gives negation.
- R4: Opcode 10 (move): the register named by [9:7] is loaded with bits [3:0].
- R5: Opcode 11 (jump if zero): if the register named by [9:7] reads 0, the PC is loaded with bits [2:0]; otherwise the PC goes up by one. A jump on register 0 to its own address holds the program there for good.
- R6: Register 0 reads as zero as an operand. A write to it is discarded.
- R7: On a clock edge with `tick` low, no register, flag or PC changes.
- R8: `disp_o` equals register 7 and changes on the same edge that writes it.
- R9: After an add or subtract, `zero_o` is 1 exactly when the 4-bit result is 0, and `ovf_o` is 1 exactly when the two's-complement result lies outside −8..7. Moves and jumps leave both flags unchanged.
- R10: A non-jump instruction at address 7 is followed by the instruction at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable: one instruction per edge while high |
| disp_o | output | 4 | Contents of register 7 |
| zero_o | output | 1 | Zero flag of the last add/subtract |
| ovf_o | output | 1 | Signed overflow flag of the last add/subtract |

## Verification
Every architectural effect of an instruction (the register write, the flag update and the PC change) lands on the clock edge at which `tick` is sampled high. So `disp_o` and both flags are due one edge after the stimulus, and they hold across every edge at which `tick` is low. The bench changes `tick` on falling edges and reads the outputs on the next falling edge. Before each read it steps its own interpreter once if the edge between them was enabled. Two looping programs cover all 256 operand pairs for add and for subtract, and a third program covers negation, discarded writes to register 0 and the self-loop stop.

// File: rtl/nano4_pkg.sv
package nano4_pkg;

  localparam int DATA_W  = 4;
  localparam int RSEL_W  = 3;
  localparam int PC_W    = 3;
  localparam int INSTR_W = 2 + 2 * RSEL_W + DATA_W;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MOV = 2'b10,
    OP_JZ  = 2'b11
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [RSEL_W-1:0]  ra;
    logic [RSEL_W-1:0]  rb;
    logic [DATA_W-1:0]  lit;
  } instr_t;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic              zero;
    logic              ovf;
  } alu_out_t;

  // Ra + Rb, or Rb - Ra when do_sub is set.
  function automatic alu_out_t alu_eval(input logic do_sub,
                                        input logic [DATA_W-1:0] ra_v,
                                        input logic [DATA_W-1:0] rb_v);
    alu_out_t o;
    if (do_sub) begin
      o.value = rb_v - ra_v;
      o.ovf   = (rb_v[DATA_W-1] != ra_v[DATA_W-1]) &&
                (o.value[DATA_W-1] != rb_v[DATA_W-1]);
    end else begin
      o.value = ra_v + rb_v;
      o.ovf   = (ra_v[DATA_W-1] == rb_v[DATA_W-1]) &&
                (o.value[DATA_W-1] != ra_v[DATA_W-1]);
    end
    o.zero = (o.value == '0);
    return o;
  endfunction

endpackage

// File: rtl/nano4_rom.sv
module nano4_rom
  import nano4_pkg::*;
#(
  parameter int                           ADDR_W = PC_W,
  parameter logic [(2**ADDR_W)*INSTR_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output instr_t            word_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [INSTR_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = IMAGE[i*INSTR_W +: INSTR_W];
  end

  assign word_o = instr_t'(words[addr]);
endmodule

// File: rtl/nano4_regbank.sv
module nano4_regbank
  import nano4_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int SELW = RSEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [SELW-1:0] raddr_a,
  output logic [W-1:0]    rdata_a,
  input  logic [SELW-1:0] raddr_b,
  output logic [W-1:0]    rdata_b,
  output logic [W-1:0]    top_o
);
  localparam int CNT = 2 ** SELW;

  logic [W-1:0]     cells [CNT];
  logic [CNT*W-1:0] flat;

  for (genvar i = 0; i < CNT; i++) begin : g_cell
    if (i == 0) begin : g_ground
      assign cells[i] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (we && waddr == SELW'(i))          q <= wdata;
      end
      assign cells[i] = q;
    end
    assign flat[i*W +: W] = cells[i];
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
  assign top_o   = cells[CNT-1];

  // R2: a write to a storage register is visible on the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> cells[$past(waddr)] == $past(wdata));

  // R6: a write aimed at index 0 leaves the whole bank untouched
  p_ground_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0) |=> $stable(flat));

  // R7: no write enable, no change
  p_bank_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/nano4_decode.sv
module nano4_decode
  import nano4_pkg::*;
#(
  parameter int AW = PC_W
) (
  input  logic              tick,
  input  instr_t            ins,
  input  logic [DATA_W-1:0] ra_val,
  output logic              rf_we,
  output logic              take_lit,
  output logic              alu_en,
  output logic              alu_sub,
  output logic              jump_taken,
  output logic [AW-1:0]     jump_target
);
  always_comb begin
    rf_we      = 1'b0;
    take_lit   = 1'b0;
    alu_en     = 1'b0;
    alu_sub    = 1'b0;
    jump_taken = 1'b0;
    unique case (ins.op)
      OP_ADD: begin
        rf_we  = tick;
        alu_en = tick;
      end
      OP_SUB: begin
        rf_we   = tick;
        alu_en  = tick;
        alu_sub = 1'b1;
      end
      OP_MOV: begin
        rf_we    = tick;
        take_lit = 1'b1;
      end
      OP_JZ: begin
        jump_taken = tick && (ra_val == '0);
      end
      default: ;
    endcase
  end

  assign jump_target = ins.lit[AW-1:0];
endmodule

// File: rtl/nano4_core.sv
module nano4_core
  import nano4_pkg::*;
#(
  parameter logic [(2**PC_W)*INSTR_W-1:0] PROGRAM = {
    12'b11_000_000_0110,   // 7: unreached
    12'b11_000_000_0110,   // 6: stop here
    12'b00_111_001_0000,   // 5: show R1
    12'b00_001_011_0000,   // 4: R1 += R3
    12'b00_001_010_0000,   // 3: R1 += R2
    12'b10_011_000_0011,   // 2: R3 = 3
    12'b10_010_000_0010,   // 1: R2 = 2
    12'b10_001_000_0001    // 0: R1 = 1
  }
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [DATA_W-1:0] disp_o,
  output logic              zero_o,
  output logic              ovf_o
);
  logic [PC_W-1:0]   pc_q;
  instr_t            ins;
  logic [DATA_W-1:0] ra_val, rb_val, wdata;
  logic              rf_we, take_lit, alu_en, alu_sub, jump_taken;
  logic [PC_W-1:0]   jump_target;
  alu_out_t          alu_res;

  nano4_rom #(.ADDR_W(PC_W), .IMAGE(PROGRAM)) u_rom (
    .addr   (pc_q),
    .word_o (ins)
  );

  nano4_regbank #(.W(DATA_W), .SELW(RSEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (ins.ra),
    .wdata   (wdata),
    .raddr_a (ins.ra),
    .rdata_a (ra_val),
    .raddr_b (ins.rb),
    .rdata_b (rb_val),
    .top_o   (disp_o)
  );

  nano4_decode #(.AW(PC_W)) u_dec (
    .tick        (tick),
    .ins         (ins),
    .ra_val      (ra_val),
    .rf_we       (rf_we),
    .take_lit    (take_lit),
    .alu_en      (alu_en),
    .alu_sub     (alu_sub),
    .jump_taken  (jump_taken),
    .jump_target (jump_target)
  );

  assign alu_res = alu_eval(alu_sub, ra_val, rb_val);
  assign wdata   = take_lit ? ins.lit : alu_res.value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (tick)       pc_q <= jump_taken ? jump_target : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else if (alu_en) begin
      zero_o <= alu_res.zero;
      ovf_o  <= alu_res.ovf;
    end
  end

  // R7: the PC holds without a tick
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pc_q));

  // R7: the display holds without a tick
  p_disp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(disp_o));

  // R5 / R10: a sequential step moves the PC by one, wrapping at the top
  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !jump_taken) |=> pc_q == PC_W'($past(pc_q) + 1));

  // R5: a taken jump lands on the literal target
  p_pc_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && jump_taken) |=> pc_q == $past(ins.lit[PC_W-1:0]));

  // R5: a jump on index 0 to its own address parks the PC
  p_self_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ins.op == OP_JZ && ins.ra == '0 && ins.lit[PC_W-1:0] == pc_q)
      |=> $stable(pc_q));

  // R9: moves and jumps leave the flags alone
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_en |=> ($stable(zero_o) && $stable(ovf_o)));

  // R9: zero flag follows the value that was written back
  p_zero_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && ins.ra == RSEL_W'(2**RSEL_W - 1)) |=> zero_o == (disp_o == '0));
endmodule

// File: tb/nano4_core_tb.sv
`timescale 1ns/1ps
module nano4_core_tb;
  localparam int NDUT = 3;

  function automatic logic [11:0] mk(input int op, input int ra, input int rb, input int lit);
    return {2'(op), 3'(ra), 3'(rb), 4'(lit)};
  endfunction

  // Sweep loop: R7 = R1 (+|-) R2, then step R1; step R2 whenever R1 wraps.
  localparam logic [95:0] PROG_ADD = {
    mk(0,2,3,0), mk(3,0,0,0), mk(3,1,0,7), mk(0,1,3,0),
    mk(2,3,0,1), mk(0,7,2,0), mk(0,7,1,0), mk(2,7,0,0)};
  localparam logic [95:0] PROG_SUB = {
    mk(0,2,3,0), mk(3,0,0,0), mk(3,1,0,7), mk(0,1,3,0),
    mk(2,3,0,1), mk(1,7,2,0), mk(0,7,1,0), mk(2,7,0,0)};
  localparam logic [95:0] PROG_MISC = {
    mk(2,7,0,15), mk(3,0,0,6), mk(0,7,1,0), mk(3,1,0,0),
    mk(1,1,0,0),  mk(0,1,0,0), mk(2,0,0,9), mk(2,1,0,5)};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] disp [NDUT];
  logic       zf   [NDUT];
  logic       of   [NDUT];

  always #2.5 clk = ~clk;

  nano4_core #(.PROGRAM(PROG_ADD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .disp_o(disp[0]), .zero_o(zf[0]), .ovf_o(of[0]));
  nano4_core #(.PROGRAM(PROG_SUB)) u_dut_sub (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .disp_o(disp[1]), .zero_o(zf[1]), .ovf_o(of[1]));
  nano4_core #(.PROGRAM(PROG_MISC)) u_dut_misc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .disp_o(disp[2]), .zero_o(zf[2]), .ovf_o(of[2]));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] mprog [NDUT][8];
  logic [3:0]  mreg  [NDUT][8];
  int          mpc   [NDUT];
  logic        mz    [NDUT];
  logic        mo    [NDUT];
  string       mtag  [NDUT];
  bit          seen_pair [2][256];

  function automatic int as_signed(input logic [3:0] v);
    return (v > 7) ? int'(v) - 16 : int'(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Independent interpreter, one instruction.
  task automatic run_model(input int k);
    logic [11:0] w;
    int op, ra, rb, a, b, s;
    w  = mprog[k][mpc[k]];
    op = int'(w[11:10]); ra = int'(w[9:7]); rb = int'(w[6:4]);
    a  = as_signed(mreg[k][ra]);
    b  = as_signed(mreg[k][rb]);
    mtag[k] = (mpc[k] == 7 && op != 3) ? "R10" : "";
    case (op)
      0, 1: begin
        if (k < 2 && ra == 7 && rb == 2) seen_pair[k][{mreg[k][7], mreg[k][2]}] = 1;
        s = (op == 0) ? a + b : b - a;
        mo[k] = (s > 7) || (s < -8);
        mz[k] = ((s % 16) == 0);
        if (ra != 0) mreg[k][ra] = 4'(s & 15);
        if (mtag[k] == "") mtag[k] = (op == 0) ? "R2" : "R3";
        mpc[k] = (mpc[k] + 1) % 8;
      end
      2: begin
        if (ra != 0) mreg[k][ra] = w[3:0];
        if (mtag[k] == "") mtag[k] = (ra == 0) ? "R6" : "R4";
        mpc[k] = (mpc[k] + 1) % 8;
      end
      default: begin
        mtag[k] = "R5";
        mpc[k] = (mreg[k][ra] == 0 || ra == 0) ? int'(w[2:0]) : (mpc[k] + 1) % 8;
      end
    endcase
  endtask

  task automatic compare_all(input bit ticked);
    for (int k = 0; k < NDUT; k++) begin
      string t;
      t = ticked ? mtag[k] : "R7";
      check({t, "/R8 display"}, int'(disp[k]), int'(mreg[k][7]));
      check({t, "/R9 zero flag"}, int'(zf[k]), int'(mz[k]));
      check({t, "/R9 overflow flag"}, int'(of[k]), int'(mo[k]));
    end
  endtask

  initial begin
    for (int k = 0; k < NDUT; k++) begin
      logic [95:0] img;
      img = (k == 0) ? PROG_ADD : (k == 1) ? PROG_SUB : PROG_MISC;
      for (int i = 0; i < 8; i++) begin
        mprog[k][i] = img[i*12 +: 12];
        mreg[k][i]  = '0;
      end
      mpc[k] = 0; mz[k] = 0; mo[k] = 0; mtag[k] = "R1";
    end

    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    for (int k = 0; k < NDUT; k++) begin
      check("R1 display in reset", int'(disp[k]), 0);
      check("R1 flags in reset", int'({zf[k], of[k]}), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(1'b0);

    // Main run: tick low on every fifth cycle, longer idle gaps now and then.
    for (int c = 0; c < 2600; c++) begin
      bit t;
      t = (c % 5 != 4) && !(c % 97 >= 90);
      tick = t;
      @(negedge clk);
      if (t) for (int k = 0; k < NDUT; k++) run_model(k);
      compare_all(t);
    end
    tick = 1'b0;

    // R2 / R3: every operand pair of the display operation was exercised.
    for (int k = 0; k < 2; k++) begin
      int n;
      n = 0;
      for (int p = 0; p < 256; p++) n += int'(seen_pair[k][p]);
      check((k == 0) ? "R2 add pairs covered" : "R3 sub pairs covered", n, 256);
    end
    // R3 / R6 / R5: misc program shows -5 and parks before the move of 15.
    check("R3 negation of 5 shown (R6 ground operand)", int'(disp[2]), 11);
    check("R5 stop loop holds display", int'(disp[2]), 11);

    // R1: a fresh reset clears everything and restarts at address 0.
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NDUT; k++) check("R1 display after reset", int'(disp[k]), 0);
    rst_n = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    // Address 0 of the misc program moves 5 into R1; the display is untouched.
    check("R1 restart keeps display clear", int'(disp[2]), 0);
    check("R1 restart flags clear", int'({zf[0], of[0]}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule